// File: doc/BRIEF.md
# Parallel Flash Command-Sequence Decoder

This block interprets the write cycles that a host issues to an asynchronous parallel NOR-style flash device. Each write strobe carries an address and a 16-bit data word. The decoder follows the multi-write unlock sequences and turns complete sequences into program or erase operations. It runs those operations against a small on-chip cell array, which the host reads through a separate registered read port.

The decoder has two modes. In normal mode every program operation must be preceded by two unlock writes. The host can also switch the decoder into a bypass mode. In bypass mode a program takes two writes and an erase takes two writes, because the unlock writes are no longer needed. Bypass mode is left only by its dedicated two-write exit sequence or by the full three-write reset sequence.

While an operation runs, `busy` stays high and every write is discarded. The `bypass_active` output reports the current mode. A `byte_mode` input selects which pair of unlock addresses is recognised.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy` and `bypass_active` are low. Every cell reads FFFFh. `rd_data` shows the cell at `rd_addr` one clock after the address is presented.
- R2: The two unlock addresses are 555h and 2AAh when `byte_mode` is 0, and AAAh and 555h when it is 1. Only bits [7:0] of the data are decoded as a command. The target word is `wr_addr[5:0]` in word mode and `wr_addr[6:1]` in byte mode.
- R3: A normal-mode program is four writes: AAh to the first unlock address, 55h to the second, A0h to the first, then the data to the target. The cell becomes its old value ANDed with that data.
- R4: Writing AAh to the first unlock address, then 55h to the second, then 20h to the first, sets `bypass_active` high on the clock after the third write.
- R5: In bypass mode, a write of A0h at any address followed by a data write to the target programs that cell, with the same AND rule as R3.
- R6: In bypass mode, 80h followed by 30h erases the 16-word sector that holds the second write's target. 80h followed by 10h erases all 64 words. Erased words become FFFFh, one word per clock in ascending order. `busy` stays high for exactly as many clocks as words are erased.
- R7: In bypass mode, 90h followed by 00h clears `bypass_active` and returns the decoder to normal read mode. 90h followed by any other value leaves the decoder in bypass mode.
- R8: In bypass mode, a lone F0h or any unlisted command is ignored. AAh to the first unlock address, then 55h to the second, then F0h to the first, leaves bypass mode.
- R9: In normal mode, a write that does not match the next expected step returns the decoder to idle. Later writes must therefore begin a new sequence.
- R10: A program holds `busy` high for 4 clocks, starting on the clock after the final write. Writes seen while `busy` is high change neither the mode nor any cell.
- R11: When a cell is read on the same clock edge that writes it, `rd_data` returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-clock bus write strobe |
| wr_addr | input | 12 | Write address (byte or word address, per `byte_mode`) |
| wr_data | input | 16 | Write data |
| byte_mode | input | 1 | 1 selects byte addressing for unlock and target decoding |
| rd_addr | input | 6 | Word index for the read port |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | Program or erase operation in progress |
| bypass_active | output | 1 | Decoder is in bypass mode |

## Verification
Two functions can fall on the same edge: the host read of a cell and the engine's write to that cell, during either a program or an erase sweep. The bench provokes this by holding `rd_addr` on the target word for the whole operation. The behavioural reference model takes the expected read value before it applies that edge's cell update, so the pre-write value is expected in that cycle and the new value one cycle later. The other overlap is a host write that lands while `busy` is high. Such a write must be ignored, and this is judged through `bypass_active` and through reads of the cells afterwards.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_U1,
    ST_U2,
    ST_PROG,
    BP_IDLE,
    BP_PROG,
    BP_ERASE,
    BP_EXIT,
    BP_R1,
    BP_R2
  } dec_state_t;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_ERASE_SEC,
    OP_ERASE_CHIP
  } op_kind_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_EXIT1  = 8'h90;
  localparam logic [7:0] CMD_EXIT2  = 8'h00;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

  function automatic logic in_bypass(dec_state_t s);
    return (s == BP_IDLE) || (s == BP_PROG) || (s == BP_ERASE) ||
           (s == BP_EXIT) || (s == BP_R1) || (s == BP_R2);
  endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 6,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              byte_mode,
  input  logic              busy,
  output logic              req_valid,
  output op_kind_t          req_kind,
  output logic [MEM_AW-1:0] req_word,
  output logic [DW-1:0]     req_data,
  output logic              bypass_active
);

  localparam logic [ADDR_W-1:0] KEYA_WORD = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] KEYB_WORD = ADDR_W'(12'h2AA);
  localparam logic [ADDR_W-1:0] KEYA_BYTE = ADDR_W'(12'hAAA);
  localparam logic [ADDR_W-1:0] KEYB_BYTE = ADDR_W'(12'h555);

  dec_state_t state_q, state_d;
  logic       bypass_q;
  logic       accept;
  logic       at_key_a, at_key_b;
  logic [7:0] cmd;

  assign accept   = wr_en && !busy;
  assign cmd      = wr_data[7:0];
  assign at_key_a = wr_addr == (byte_mode ? KEYA_BYTE : KEYA_WORD);
  assign at_key_b = wr_addr == (byte_mode ? KEYB_BYTE : KEYB_WORD);
  assign req_word = byte_mode ? wr_addr[MEM_AW:1] : wr_addr[MEM_AW-1:0];
  assign req_data = wr_data;

  always_comb begin
    state_d   = state_q;
    req_valid = 1'b0;
    req_kind  = OP_PROG;
    if (accept) begin
      case (state_q)
        ST_IDLE:  state_d = (at_key_a && cmd == CMD_KEY1) ? ST_U1 : ST_IDLE;
        ST_U1:    state_d = (at_key_b && cmd == CMD_KEY2) ? ST_U2 : ST_IDLE;
        ST_U2: begin
          if (at_key_a && cmd == CMD_BYPASS)    state_d = BP_IDLE;
          else if (at_key_a && cmd == CMD_PROG) state_d = ST_PROG;
          else                                  state_d = ST_IDLE;
        end
        ST_PROG: begin
          req_valid = 1'b1;
          state_d   = ST_IDLE;
        end
        BP_IDLE: begin
          if (cmd == CMD_PROG)                  state_d = BP_PROG;
          else if (cmd == CMD_ERASE)            state_d = BP_ERASE;
          else if (cmd == CMD_EXIT1)            state_d = BP_EXIT;
          else if (at_key_a && cmd == CMD_KEY1) state_d = BP_R1;
          else                                  state_d = BP_IDLE;
        end
        BP_PROG: begin
          req_valid = 1'b1;
          state_d   = BP_IDLE;
        end
        BP_ERASE: begin
          if (cmd == CMD_SECTOR) begin
            req_valid = 1'b1;
            req_kind  = OP_ERASE_SEC;
          end else if (cmd == CMD_CHIP) begin
            req_valid = 1'b1;
            req_kind  = OP_ERASE_CHIP;
          end
          state_d = BP_IDLE;
        end
        BP_EXIT:  state_d = (cmd == CMD_EXIT2) ? ST_IDLE : BP_IDLE;
        BP_R1:    state_d = (at_key_b && cmd == CMD_KEY2) ? BP_R2 : BP_IDLE;
        BP_R2:    state_d = (at_key_a && cmd == CMD_RESET) ? ST_IDLE : BP_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bypass_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bypass_q <= in_bypass(state_d);
    end
  end

  assign bypass_active = bypass_q;

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW   = 6,
  parameter int SEC_AW   = 4,
  parameter int DW       = 16,
  parameter int PROG_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  op_kind_t          req_kind,
  input  logic [MEM_AW-1:0] req_word,
  input  logic [DW-1:0]     req_data,
  input  logic [DW-1:0]     rdata_a,
  output logic              busy,
  output logic              en_a,
  output logic              we_a,
  output logic [MEM_AW-1:0] addr_a,
  output logic [DW-1:0]     wdata_a
);

  localparam int WORDS     = 1 << MEM_AW;
  localparam int SEC_WORDS = 1 << SEC_AW;
  localparam int CNT_W     = $clog2(WORDS + PROG_LAT) + 1;

  typedef enum logic [1:0] {PH_READ, PH_WRITE, PH_WAIT} phase_t;

  logic              busy_q;
  op_kind_t          kind_q;
  phase_t            phase_q;
  logic [MEM_AW-1:0] cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DW-1:0]     data_q;
  logic              is_erase;

  assign is_erase = kind_q != OP_PROG;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      kind_q  <= OP_PROG;
      phase_q <= PH_READ;
      cur_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
      if (is_erase)                   cur_q   <= cur_q + MEM_AW'(1);
      else if (phase_q == PH_READ)    phase_q <= PH_WRITE;
      else if (phase_q == PH_WRITE)   phase_q <= PH_WAIT;
    end else if (req_valid) begin
      busy_q  <= 1'b1;
      kind_q  <= req_kind;
      phase_q <= PH_READ;
      data_q  <= req_data;
      case (req_kind)
        OP_ERASE_SEC: begin
          cur_q <= {req_word[MEM_AW-1:SEC_AW], {SEC_AW{1'b0}}};
          cnt_q <= CNT_W'(SEC_WORDS - 1);
        end
        OP_ERASE_CHIP: begin
          cur_q <= '0;
          cnt_q <= CNT_W'(WORDS - 1);
        end
        default: begin
          cur_q <= req_word;
          cnt_q <= CNT_W'(PROG_LAT - 1);
        end
      endcase
    end
  end

  assign busy    = busy_q;
  assign addr_a  = cur_q;
  assign en_a    = busy_q && (is_erase || phase_q != PH_WAIT);
  assign we_a    = busy_q && (is_erase || phase_q == PH_WRITE);
  assign wdata_a = is_erase ? {DW{1'b1}} : (rdata_a & data_q);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int MEM_AW = 6,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              en_a,
  input  logic              we_a,
  input  logic [MEM_AW-1:0] addr_a,
  input  logic [DW-1:0]     wdata_a,
  output logic [DW-1:0]     rdata_a,
  input  logic [MEM_AW-1:0] addr_b,
  output logic [DW-1:0]     rdata_b
);

  localparam int WORDS = 1 << MEM_AW;

  logic [DW-1:0] cells [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) cells[i] = {DW{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (en_a) begin
      rdata_a <= cells[addr_a];
      if (we_a) cells[addr_a] <= wdata_a;
    end
    rdata_b <= cells[addr_b];
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int MEM_AW   = 6,
  parameter int SEC_AW   = 4,
  parameter int DW       = 16,
  parameter int PROG_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              byte_mode,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              busy,
  output logic              bypass_active
);

  logic              req_valid;
  op_kind_t          req_kind;
  logic [MEM_AW-1:0] req_word;
  logic [DW-1:0]     req_data;
  logic              mem_en, mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [DW-1:0]     mem_wdata, mem_rdata;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_mode(byte_mode), .busy(busy), .req_valid(req_valid), .req_kind(req_kind),
    .req_word(req_word), .req_data(req_data), .bypass_active(bypass_active)
  );

  flash_op_engine #(.MEM_AW(MEM_AW), .SEC_AW(SEC_AW), .DW(DW), .PROG_LAT(PROG_LAT)) u_eng (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_word(req_word), .req_data(req_data), .rdata_a(mem_rdata), .busy(busy),
    .en_a(mem_en), .we_a(mem_we), .addr_a(mem_addr), .wdata_a(mem_wdata)
  );

  flash_cell_array #(.MEM_AW(MEM_AW), .DW(DW)) u_mem (
    .clk(clk), .en_a(mem_en), .we_a(mem_we), .addr_a(mem_addr), .wdata_a(mem_wdata),
    .rdata_a(mem_rdata), .addr_b(rd_addr), .rdata_b(rd_data)
  );

endmodule

// File: rtl/flash_cmd_decoder_sva.sv
module flash_cmd_decoder_sva #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          bypass_active,
  input logic          mem_we
);

  // R1: reset clears both status outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!busy && !bypass_active));

  // R4: bypass is entered only on an accepted 20h write
  a_r4_entry_cause: assert property (@(posedge clk) disable iff (rst)
    ($rose(bypass_active) && $past(!rst)) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h20));

  // R7 / R8: bypass is left only by 00h (exit) or F0h (full reset)
  a_r7_exit_cause: assert property (@(posedge clk) disable iff (rst)
    ($fell(bypass_active) && $past(!rst)) |->
      ($past(wr_en) && ($past(wr_data[7:0]) == 8'h00 || $past(wr_data[7:0]) == 8'hF0)));

  // R10: mode cannot change while an operation runs
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(bypass_active));

  // R10: cells are written only during a busy interval
  a_r10_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R6 / R10: an operation starts only after an accepted write
  a_r6_busy_start: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(!rst)) |-> $past(wr_en));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .bypass_active(bypass_active), .mem_we(mem_we)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int WORDS = 64;
  localparam int SECW  = 16;
  localparam int PLAT  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        byte_mode = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy, bypass_active;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_mode(byte_mode), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .bypass_active(bypass_active)
  );

  always #5 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    armed = 0;

  // ---------------- reference model ----------------
  logic [15:0] m_mem [WORDS];
  logic [15:0] exp_rd;
  bit          m_busy, m_byp;
  int          m_step, m_cnt, m_cur, m_kind, m_ph;
  logic [15:0] m_d;

  initial for (int i = 0; i < WORDS; i++) m_mem[i] = 16'hFFFF;

  task automatic m_start(int kind, int word, logic [15:0] d);
    m_busy = 1; m_kind = kind; m_ph = 0; m_d = d;
    if (kind == 0)      begin m_cur = word;              m_cnt = PLAT - 1;  end
    else if (kind == 1) begin m_cur = word & ~(SECW - 1); m_cnt = SECW - 1;  end
    else                begin m_cur = 0;                 m_cnt = WORDS - 1; end
  endtask

  always @(posedge clk) begin
    exp_rd = m_mem[rd_addr];
    if (rst) begin
      m_busy = 0; m_byp = 0; m_step = 0;
    end else begin
      bit b0;
      int ka, kb, tw;
      logic [7:0] c;
      b0 = m_busy;
      if (m_busy) begin
        if (m_kind == 0) begin
          if (m_ph == 1) m_mem[m_cur] = m_mem[m_cur] & m_d;
          m_ph++;
        end else begin
          m_mem[m_cur] = 16'hFFFF;
          m_cur++;
        end
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end
      if (wr_en && !b0) begin
        ka = byte_mode ? 'hAAA : 'h555;
        kb = byte_mode ? 'h555 : 'h2AA;
        tw = byte_mode ? int'(wr_addr[6:1]) : int'(wr_addr[5:0]);
        c  = wr_data[7:0];
        if (!m_byp) begin
          case (m_step)
            0: m_step = (wr_addr == ka && c == 8'hAA) ? 1 : 0;
            1: m_step = (wr_addr == kb && c == 8'h55) ? 2 : 0;
            2: begin
              m_step = 0;
              if (wr_addr == ka && c == 8'h20) m_byp = 1;
              else if (wr_addr == ka && c == 8'hA0) m_step = 3;
            end
            default: begin m_start(0, tw, wr_data); m_step = 0; end
          endcase
        end else begin
          case (m_step)
            0: begin
              if (c == 8'hA0) m_step = 1;
              else if (c == 8'h80) m_step = 2;
              else if (c == 8'h90) m_step = 3;
              else if (c == 8'hAA && wr_addr == ka) m_step = 4;
            end
            1: begin m_start(0, tw, wr_data); m_step = 0; end
            2: begin
              if (c == 8'h30) m_start(1, tw, wr_data);
              else if (c == 8'h10) m_start(2, tw, wr_data);
              m_step = 0;
            end
            3: begin if (c == 8'h00) m_byp = 0; m_step = 0; end
            4: m_step = (c == 8'h55 && wr_addr == kb) ? 5 : 0;
            default: begin if (c == 8'hF0 && wr_addr == ka) m_byp = 0; m_step = 0; end
          endcase
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !rst) begin
      check(rd_data == exp_rd, cur_req, "rd_data", int'(rd_data), int'(exp_rd));
      check(busy == m_busy, cur_req, "busy", int'(busy), int'(m_busy));
      check(bypass_active == m_byp, cur_req, "bypass_active", int'(bypass_active), int'(m_byp));
    end
  end

  task automatic wr(logic [11:0] a, logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd_chk(logic [5:0] w, logic [15:0] e, string req);
    rd_addr = w;
    @(negedge clk);
    @(negedge clk);
    check(rd_data == e, req, "read cell", int'(rd_data), int'(e));
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic std_prog(logic [11:0] a, logic [15:0] d);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic enter_bypass();
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0020);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    armed = 1;
    // R1 reset state
    cur_req = "R1";
    check(!busy && !bypass_active, "R1", "status after reset", {busy, bypass_active}, 0);
    rd_chk(6'd3, 16'hFFFF, "R1");

    // R3 standard program, then AND rule
    cur_req = "R3";
    std_prog(12'h005, 16'h1234);
    count_busy(n);
    check(n == PLAT, "R10", "program busy clocks", n, PLAT);
    rd_chk(6'd5, 16'h1234, "R3");
    std_prog(12'h005, 16'hFF0F);
    wait_idle();
    rd_chk(6'd5, 16'h1204, "R3");

    // R9 mismatch drops to idle
    cur_req = "R9";
    wr(12'h555, 16'h00AA); wr(12'h123, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h006, 16'h0000);
    @(negedge clk);
    check(!busy, "R9", "no op after broken sequence", int'(busy), 0);
    rd_chk(6'd6, 16'hFFFF, "R9");

    // R2 byte mode addresses
    cur_req = "R2";
    byte_mode = 1'b1;
    std_prog(12'h00E, 16'h0000);
    @(negedge clk);
    check(!busy, "R2", "word keys ignored in byte mode", int'(busy), 0);
    wr(12'hAAA, 16'h00AA); wr(12'h555, 16'h0055); wr(12'hAAA, 16'h00A0); wr(12'h00E, 16'h00FF);
    wait_idle();
    rd_chk(6'd7, 16'h00FF, "R2");
    byte_mode = 1'b0;

    // R4 bypass entry
    cur_req = "R4";
    enter_bypass();
    check(bypass_active, "R4", "bypass after entry", int'(bypass_active), 1);

    // R5 two-write program, R10 writes during busy ignored
    cur_req = "R5";
    wr(12'h3FF, 16'h00A0); wr(12'h009, 16'h0F0F);
    cur_req = "R10";
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
    wait_idle();
    check(bypass_active, "R10", "exit during busy ignored", int'(bypass_active), 1);
    rd_chk(6'd9, 16'h0F0F, "R5");

    // R11 read of the cell being programmed
    cur_req = "R11";
    rd_addr = 6'd10;
    wr(12'h000, 16'h00A0); wr(12'h00A, 16'h5A5A);
    wait_idle();
    rd_chk(6'd10, 16'h5A5A, "R11");

    // R8 lone F0 and unlisted data ignored, full reset exits
    cur_req = "R8";
    wr(12'h000, 16'h00F0); wr(12'h000, 16'h0055); wr(12'h000, 16'h0020);
    @(negedge clk);
    check(bypass_active && !busy, "R8", "ignored writes in bypass", {bypass_active, busy}, 2);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00F0);
    check(!bypass_active, "R8", "full reset leaves bypass", int'(bypass_active), 0);
    enter_bypass();

    // R6 sector erase with concurrent read, then chip erase
    cur_req = "R6";
    wr(12'h000, 16'h00A0); wr(12'h014, 16'h0000);
    wait_idle();
    rd_addr = 6'd3;
    wr(12'h000, 16'h0080); wr(12'h005, 16'h0030);
    count_busy(n);
    check(n == SECW, "R6", "sector erase busy clocks", n, SECW);
    rd_chk(6'd5, 16'hFFFF, "R6");
    rd_chk(6'd20, 16'h0000, "R6");
    wr(12'h000, 16'h0080); wr(12'h000, 16'h0010);
    count_busy(n);
    check(n == WORDS, "R6", "chip erase busy clocks", n, WORDS);
    rd_chk(6'd20, 16'hFFFF, "R6");

    // R7 exit sequence
    cur_req = "R7";
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0055);
    check(bypass_active, "R7", "broken exit stays in bypass", int'(bypass_active), 1);
    wr(12'h000, 16'h0090); wr(12'h123, 16'h0000);
    check(!bypass_active, "R7", "exit leaves bypass", int'(bypass_active), 0);
    cur_req = "R9";
    wr(12'h000, 16'h00A0); wr(12'h00B, 16'h0000);
    @(negedge clk);
    rd_chk(6'd11, 16'hFFFF, "R9");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule